// File: doc/BRIEF.md
# Converter Startup and Voltage Fault Sequencer

This block is the top-level control state machine of a synchronous buck regulator. It works only on digital flags: the analog comparators, the reference DAC and the PWM modulator sit outside it. It decides when the regulator may switch. It owns the start order, in this sequence: the reset wait after enable, the bootstrap refresh, the soft-start ramp, and the power-good qualification window. It also decides how the converter backs off from faults: supply undervoltage, output under- and over-voltage, over-temperature, and over-current hiccup requests from a neighbouring block.

The outputs are the permission levels used by the rest of the controller:
- a ramp-enable and a force-to-zero level for the reference DAC;
- separate enables for the high-side and low-side gate drivers;
- a pull-down request for an open-drain power-good pin.

All durations are parameters counted in clock cycles. Each hiccup length is a multiple of the soft-start period.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, and while enable stays low, both gate enables and the ramp enable are 0, force-to-zero is 1, and the power-good pull-down is 1 (pin low).
- R2: One clock edge after enable is sampled high, a reset wait of RST_CYC cycles begins, with every output in its R1 value. A bootstrap refresh of BST_CYC cycles follows, with only the low-side enable at 1. Soft start then begins: ramp enable is 1, both gate enables are 1, and force-to-zero is 0. It lasts SS_CYC cycles.
- R3: After soft start, the pull-down is released only once the feedback has stayed inside the window (neither the low nor the high comparator set) for PGOOD_CYC consecutive cycles. Any cycle outside the window restarts the count.
- R4: While enable is low, gates are off and force-to-zero is 1 from the next cycle. This holds in every state and overrides every fault. Power-good keeps its level for PGOFF_CYC cycles and is then pulled low.
- R5: A supply undervoltage flag has two effects on the next edge: it turns all gates off and pulls power-good low. When supply-OK returns, the block runs a bootstrap refresh and then soft start, without the reset wait.
- R6: An under-voltage trip needs the low comparator set for UV_DB_CYC consecutive cycles. This count runs only after power-good has been released. A shorter pulse is ignored because the count restarts.
- R7: On an under-voltage trip, the high-side enable goes to 0 and the low-side enable stays at 1. Power-good stays released until zero-current is seen. Then both gates go off, power-good is pulled low, and a hiccup of UV_HIC_N soft-start periods runs before the bootstrap refresh and soft start.
- R8: An over-voltage trip needs the high comparator set for OV_DB_CYC consecutive cycles. It is checked from the start of soft start. On a trip, the block sets the high-side enable to 0, the low-side enable to 1 and force-to-zero to 1, and pulls power-good low. After OV_HIC_N soft-start periods, counted from the trip, a bootstrap refresh and soft start follow.
- R9: During an over-voltage hold, a negative-current-limit flag turns the low-side enable off for at least NEG_OFF_CYC cycles. It turns back on only if the high comparator is still set; otherwise it stays off.
- R10: Over-temperature is checked from soft start onward and turns every gate off. It is ignored during the reset wait and the bootstrap refresh. The recovery flag restarts the block with a bootstrap refresh and then soft start.
- R11: A hiccup request from the over-current block has the following effect, from soft start onward. The high-side enable goes to 0 and the low-side enable stays at 1 until zero-current is seen. A hiccup of OCP_HIC_N soft-start periods then runs. Power-good is not released by this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| vcc_ok_i | input | 1 | Controller supply above the restart level |
| vcc_uv_i | input | 1 | Controller supply below the lockout level |
| fb_low_i | input | 1 | Feedback below the under-voltage threshold |
| fb_high_i | input | 1 | Feedback above the over-voltage threshold |
| ot_i | input | 1 | Die temperature above the shutdown level |
| temp_rec_i | input | 1 | Die temperature below the recovery level |
| ls_neg_lim_i | input | 1 | Low-side negative current limit reached |
| zc_i | input | 1 | Inductor current crossed zero |
| ocp_hiccup_i | input | 1 | Hiccup request from the over-current block |
| ref_ramp_o | output | 1 | Reference DAC ramp enable |
| ref_zero_o | output | 1 | Force the reference DAC to zero |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pg_pulldown_o | output | 1 | 1 pulls the open-drain power-good pin low |

## Verification
The hardest state to reach from the ports is the low-side re-enable decision inside an over-voltage hold. To get there, the bench must do four things in order: complete a full start-up, keep the high comparator set through the over-voltage debounce, raise the negative-current flag while the low side is on, and then hold or drop the high comparator exactly as the minimum off time expires. The vector table walks one continuous scenario in which each row's cycle count is derived from the parameters. The hold is therefore entered with known timer values, and both outcomes are checked: re-enable and stay-off. A second row pair breaks an under-voltage pulse one cycle short of the debounce. This shows that the count restarts rather than accumulates.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
// Shared types for the converter startup and fault sequencer.
// Assumes all users compile this package first.
package pwr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,   // disabled, everything off
        ST_RST   = 4'd1,   // reset wait after enable
        ST_BST   = 4'd2,   // bootstrap refresh, low side only
        ST_SS    = 4'd3,   // reference ramp
        ST_PGD   = 4'd4,   // power-good qualification
        ST_RUN   = 4'd5,   // regulating, power-good released
        ST_DRAIN = 4'd6,   // high side off, low side on until zero current
        ST_OVP   = 4'd7,   // over-voltage hold with reference at zero
        ST_HIC   = 4'd8,   // hiccup idle time
        ST_TSD   = 4'd9,   // thermal shutdown
        ST_UVLO  = 4'd10,  // controller supply lockout
        ST_OFF   = 4'd11   // enable low, power-good release delay
    } seq_state_t;

    typedef enum logic {
        CAUSE_UV  = 1'b0,
        CAUSE_OCP = 1'b1
    } drain_cause_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_seq_debounce.sv
`timescale 1ns/1ps
// Consecutive-cycle qualifier for one comparator flag.
// Trips once raw_i has been high on N consecutive edges while arm_i is set;
// any low cycle or disarm restarts the count. Assumes N >= 1.
module pwr_seq_debounce #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic raw_i,
    output logic trip_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] FULL = CW'(N);

    logic [CW-1:0] cnt_q;

    // count consecutive qualified cycles, saturating at N
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_i && raw_i) begin
            if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
        end else begin
            cnt_q <= '0;
        end
    end

    assign trip_o = (cnt_q == FULL);

    // a trip is only ever reported right after a qualified cycle
    assert_db_needs_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> $past(raw_i && arm_i));

endmodule

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
// Free-running state timer: cleared on request, otherwise counts up and
// saturates at all ones. Assumes W is wide enough for the longest interval.
module pwr_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    // clear or advance the elapsed-cycle count
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pwr_seq_ovp_ls.sv
`timescale 1ns/1ps
// Low-side control during an over-voltage hold. The low side starts on;
// a negative-current flag turns it off for at least OFF_CYC cycles, after
// which it returns only while the over-voltage comparator is still set.
// Assumes OFF_CYC >= 2; state is rearmed whenever the hold is inactive.
module pwr_seq_ovp_ls #(
    parameter int OFF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic neg_lim_i,
    input  logic fb_high_i,
    output logic ls_on_o
);
    localparam int CW = $clog2(OFF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(OFF_CYC - 1);

    logic          on_q;
    logic [CW-1:0] cnt_q;

    // low-side on/off with a minimum off window
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            on_q  <= 1'b1;
            cnt_q <= '0;
        end else if (on_q) begin
            if (neg_lim_i) on_q <= 1'b0;
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end else if (fb_high_i) begin
            on_q <= 1'b1;
        end
    end

    assign ls_on_o = on_q;

    // once turned off, the low side stays off on the following cycle too
    assert_negoff_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $fell(on_q)) |=> !on_q);

endmodule

// File: rtl/pwr_seq_top.sv
`timescale 1ns/1ps
// Converter startup and voltage fault sequencer.
// Orders enable, reset wait, bootstrap refresh, soft start and power-good,
// and handles supply, under/over-voltage, thermal and over-current hiccup
// faults. All inputs are assumed synchronous to clk; durations are cycles.
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int RST_CYC     = 160000,
    parameter int BST_CYC     = 2000,
    parameter int SS_CYC      = 200000,
    parameter int PGOOD_CYC   = 20000,
    parameter int PGOFF_CYC   = 200,
    parameter int UV_DB_CYC   = 400,
    parameter int OV_DB_CYC   = 200,
    parameter int NEG_OFF_CYC = 128,
    parameter int UV_HIC_N    = 5,
    parameter int OV_HIC_N    = 8,
    parameter int OCP_HIC_N   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic vcc_ok_i,
    input  logic vcc_uv_i,
    input  logic fb_low_i,
    input  logic fb_high_i,
    input  logic ot_i,
    input  logic temp_rec_i,
    input  logic ls_neg_lim_i,
    input  logic zc_i,
    input  logic ocp_hiccup_i,
    output logic ref_ramp_o,
    output logic ref_zero_o,
    output logic hs_en_o,
    output logic ls_en_o,
    output logic pg_pulldown_o
);
    localparam int UV_HIC  = UV_HIC_N * SS_CYC;
    localparam int OV_HIC  = OV_HIC_N * SS_CYC;
    localparam int OCP_HIC = OCP_HIC_N * SS_CYC;
    localparam int MAXC = imax(imax(imax(RST_CYC, BST_CYC), imax(SS_CYC, PGOOD_CYC)),
                               imax(imax(PGOFF_CYC, UV_HIC), imax(OV_HIC, OCP_HIC)));
    localparam int TW = $clog2(MAXC + 1);

    localparam logic [TW-1:0] RST_END  = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] BST_END  = TW'(BST_CYC - 1);
    localparam logic [TW-1:0] SS_END   = TW'(SS_CYC - 1);
    localparam logic [TW-1:0] PG_END   = TW'(PGOOD_CYC - 1);
    localparam logic [TW-1:0] OFF_END  = TW'(PGOFF_CYC - 1);
    localparam logic [TW-1:0] UVH_END  = TW'(UV_HIC - 1);
    localparam logic [TW-1:0] OVH_END  = TW'(OV_HIC - 1);
    localparam logic [TW-1:0] OCPH_END = TW'(OCP_HIC - 1);

    seq_state_t   st_q, st_d;
    drain_cause_t cause_q, cause_d;
    logic         pg_q, pg_d;
    logic [TW-1:0] tmr;
    logic         tmr_clr;
    logic         win, armed_ss, ot_armed, uv_armed;
    logic         ovp_trip, uvp_trip, ovp_ls_on;
    logic [TW-1:0] hic_end;

    // qualification windows derived from the current state
    always_comb begin
        win      = !fb_low_i && !fb_high_i;
        armed_ss = (st_q inside {ST_SS, ST_PGD, ST_RUN});
        ot_armed = armed_ss || (st_q inside {ST_DRAIN, ST_OVP, ST_HIC});
        uv_armed = !(st_q inside {ST_IDLE, ST_OFF, ST_UVLO});
        hic_end  = (cause_q == CAUSE_UV) ? UVH_END : OCPH_END;
    end

    pwr_seq_debounce #(.N(OV_DB_CYC)) u_ovp_db (
        .clk(clk), .rst_n(rst_n), .arm_i(armed_ss), .raw_i(fb_high_i), .trip_o(ovp_trip)
    );

    pwr_seq_debounce #(.N(UV_DB_CYC)) u_uvp_db (
        .clk(clk), .rst_n(rst_n), .arm_i(st_q == ST_RUN), .raw_i(fb_low_i), .trip_o(uvp_trip)
    );

    pwr_seq_ovp_ls #(.OFF_CYC(NEG_OFF_CYC)) u_ovp_ls (
        .clk(clk), .rst_n(rst_n), .active_i(st_q == ST_OVP),
        .neg_lim_i(ls_neg_lim_i), .fb_high_i(fb_high_i), .ls_on_o(ovp_ls_on)
    );

    pwr_seq_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .cnt_o(tmr)
    );

    // next state: enable low first, then supply, thermal, OVP, UVP, OCP
    always_comb begin
        st_d    = st_q;
        cause_d = cause_q;
        if (!en_i) begin
            if (st_q == ST_OFF) begin
                if (tmr == OFF_END) st_d = ST_IDLE;
            end else if (st_q != ST_IDLE) begin
                st_d = ST_OFF;
            end
        end else if (st_q == ST_OFF) begin
            if (tmr == OFF_END) st_d = ST_IDLE;
        end else if (uv_armed && vcc_uv_i) begin
            st_d = ST_UVLO;
        end else if (ot_armed && ot_i) begin
            st_d = ST_TSD;
        end else if (armed_ss && ovp_trip) begin
            st_d = ST_OVP;
        end else if (st_q == ST_RUN && uvp_trip) begin
            st_d    = ST_DRAIN;
            cause_d = CAUSE_UV;
        end else if (armed_ss && ocp_hiccup_i) begin
            st_d    = ST_DRAIN;
            cause_d = CAUSE_OCP;
        end else begin
            case (st_q)
                ST_IDLE:  st_d = ST_RST;
                ST_RST:   if (tmr == RST_END) st_d = ST_BST;
                ST_BST:   if (tmr == BST_END) st_d = ST_SS;
                ST_SS:    if (tmr == SS_END) st_d = ST_PGD;
                ST_PGD:   if (win && tmr == PG_END) st_d = ST_RUN;
                ST_DRAIN: if (zc_i) st_d = ST_HIC;
                ST_OVP:   if (tmr == OVH_END) st_d = ST_BST;
                ST_HIC:   if (tmr == hic_end) st_d = ST_BST;
                ST_TSD:   if (temp_rec_i) st_d = ST_BST;
                ST_UVLO:  if (vcc_ok_i) st_d = ST_BST;
                default:  st_d = st_q;
            endcase
        end
    end

    // timer restarts on each state change and whenever the window is left
    always_comb begin
        tmr_clr = (st_d != st_q) || (st_q == ST_PGD && !win);
        pg_d    = (st_d == ST_RUN) || ((st_d == ST_DRAIN || st_d == ST_OFF) && pg_q);
    end

    // state, drain cause and power-good registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cause_q <= CAUSE_UV;
            pg_q    <= 1'b0;
        end else begin
            st_q    <= st_d;
            cause_q <= cause_d;
            pg_q    <= pg_d;
        end
    end

    // output decode from registered state
    always_comb begin
        ref_ramp_o    = (st_q == ST_SS);
        hs_en_o       = (st_q inside {ST_SS, ST_PGD, ST_RUN});
        ref_zero_o    = !hs_en_o;
        ls_en_o       = hs_en_o || (st_q == ST_BST) || (st_q == ST_DRAIN)
                        || (st_q == ST_OVP && ovp_ls_on);
        pg_pulldown_o = !pg_q;
    end

    assert_en_low_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!hs_en_o && !ls_en_o && ref_zero_o));

    assert_uvlo_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && uv_armed && vcc_uv_i) |=> (pg_pulldown_o && !hs_en_o && !ls_en_o));

    assert_pg_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pg_pulldown_o) |-> $past(st_q == ST_PGD));

    assert_drain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRAIN && en_i && !vcc_uv_i && !ot_i && !zc_i) |=> (ls_en_o && !hs_en_o));

    assert_ovp_trip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && armed_ss && ovp_trip) |=> (!hs_en_o && ref_zero_o && pg_pulldown_o));

    assert_ot_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ot_armed && ot_i) |=> (!hs_en_o && !ls_en_o));

endmodule

// File: tb/pwr_seq_top_tb.sv
`timescale 1ns/1ps
// Self-checking bench: one continuous scenario from a vector table, then
// directed checks of reset and the power-good window restart.
module pwr_seq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, vok = 1'b1, vuv = 1'b0, flo = 1'b0, fhi = 1'b0;
    logic ot = 1'b0, rec = 1'b0, neg = 1'b0, zc = 1'b0, ocp = 1'b0;
    logic ramp, zero, hs, ls, pgpd;
    int   checks = 0;
    int   bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    pwr_seq_top #(
        .RST_CYC(4), .BST_CYC(6), .SS_CYC(10), .PGOOD_CYC(8), .PGOFF_CYC(3),
        .UV_DB_CYC(4), .OV_DB_CYC(3), .NEG_OFF_CYC(4),
        .UV_HIC_N(5), .OV_HIC_N(8), .OCP_HIC_N(6)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .vcc_ok_i(vok), .vcc_uv_i(vuv),
        .fb_low_i(flo), .fb_high_i(fhi), .ot_i(ot), .temp_rec_i(rec),
        .ls_neg_lim_i(neg), .zc_i(zc), .ocp_hiccup_i(ocp),
        .ref_ramp_o(ramp), .ref_zero_o(zero), .hs_en_o(hs), .ls_en_o(ls),
        .pg_pulldown_o(pgpd)
    );

    // fields: req[26:23] cycles[22:15]
    // inputs[14:5] = en vok vuv flo fhi ot rec neg zc ocp
    // expect[4:0]  = ramp zero hs ls pgood
    localparam int NV = 50;
    localparam logic [26:0] VEC [NV] = '{
        {4'd1,  8'd2,  10'b0100000000, 5'b01000},  // R1 idle with enable low
        {4'd2,  8'd1,  10'b1100000000, 5'b01000},  // R2 reset wait begins
        {4'd2,  8'd3,  10'b1100000000, 5'b01000},  // R2 last reset-wait cycle
        {4'd2,  8'd1,  10'b1100000000, 5'b01010},  // R2 bootstrap refresh
        {4'd2,  8'd5,  10'b1100000000, 5'b01010},
        {4'd2,  8'd1,  10'b1100000000, 5'b10110},  // R2 soft start
        {4'd2,  8'd9,  10'b1100000000, 5'b10110},
        {4'd3,  8'd1,  10'b1100000000, 5'b00110},  // R3 qualification
        {4'd3,  8'd7,  10'b1100000000, 5'b00110},
        {4'd3,  8'd1,  10'b1100000000, 5'b00111},  // R3 power good released
        {4'd6,  8'd3,  10'b1101000000, 5'b00111},  // R6 pulse one short
        {4'd6,  8'd1,  10'b1100000000, 5'b00111},
        {4'd6,  8'd3,  10'b1101000000, 5'b00111},  // R6 count restarted
        {4'd7,  8'd2,  10'b1101000000, 5'b01011},  // R7 drain, pg still good
        {4'd7,  8'd3,  10'b1101000000, 5'b01011},
        {4'd7,  8'd1,  10'b1100000010, 5'b01000},  // R7 zero current -> hiccup
        {4'd7,  8'd49, 10'b1100000000, 5'b01000},
        {4'd7,  8'd1,  10'b1100000000, 5'b01010},
        {4'd7,  8'd6,  10'b1100000000, 5'b10110},
        {4'd3,  8'd10, 10'b1100000000, 5'b00110},
        {4'd8,  8'd3,  10'b1100100000, 5'b00110},  // R8 debounce running
        {4'd8,  8'd1,  10'b1100100000, 5'b01010},  // R8 over-voltage hold
        {4'd9,  8'd1,  10'b1100100100, 5'b01000},  // R9 negative limit
        {4'd9,  8'd3,  10'b1100100000, 5'b01000},
        {4'd9,  8'd1,  10'b1100100000, 5'b01010},  // R9 back on
        {4'd9,  8'd1,  10'b1100100100, 5'b01000},
        {4'd9,  8'd5,  10'b1100000000, 5'b01000},  // R9 stays off, cleared
        {4'd8,  8'd68, 10'b1100000000, 5'b01000},
        {4'd8,  8'd1,  10'b1100000000, 5'b01010},  // R8 hiccup over
        {4'd8,  8'd6,  10'b1100000000, 5'b10110},
        {4'd10, 8'd1,  10'b1100010000, 5'b01000},  // R10 thermal trip
        {4'd10, 8'd3,  10'b1100000000, 5'b01000},
        {4'd10, 8'd1,  10'b1100001000, 5'b01010},  // R10 recovery
        {4'd10, 8'd2,  10'b1100010000, 5'b01010},  // R10 ignored in refresh
        {4'd10, 8'd4,  10'b1100000000, 5'b10110},
        {4'd11, 8'd1,  10'b1100000001, 5'b01010},  // R11 hiccup request
        {4'd11, 8'd1,  10'b1100000010, 5'b01000},
        {4'd11, 8'd59, 10'b1100000000, 5'b01000},
        {4'd11, 8'd1,  10'b1100000000, 5'b01010},
        {4'd11, 8'd6,  10'b1100000000, 5'b10110},
        {4'd3,  8'd10, 10'b1100000000, 5'b00110},
        {4'd3,  8'd8,  10'b1100000000, 5'b00111},
        {4'd4,  8'd1,  10'b0110000000, 5'b01001},  // R4 beats supply fault
        {4'd4,  8'd2,  10'b0110000000, 5'b01001},
        {4'd4,  8'd1,  10'b0110000000, 5'b01000},
        {4'd2,  8'd1,  10'b1100000000, 5'b01000},
        {4'd5,  8'd1,  10'b1010000000, 5'b01000},  // R5 lockout
        {4'd5,  8'd3,  10'b1010000000, 5'b01000},
        {4'd5,  8'd1,  10'b1100000000, 5'b01010},  // R5 refresh, no reset wait
        {4'd5,  8'd6,  10'b1100000000, 5'b10110}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {ramp, zero, hs, ls, ~pgpd};
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            {en, vok, vuv, flo, fhi, ot, rec, neg, zc, ocp} = VEC[i][14:5];
            tick(int'(VEC[i][22:15]));
            chk($sformatf("R%0d row %0d", VEC[i][26:23], i), VEC[i][4:0]);
        end
        // R1: reset taken in the middle of soft start
        rst_n = 1'b0;
        tick(2);
        chk("R1 reset during soft start", 5'b01000);
        rst_n = 1'b1;
        tick(21);
        chk("R3 qualification entered", 5'b00110);
        tick(5);
        flo = 1'b1;
        tick(1);
        flo = 1'b0;
        tick(7);
        chk("R3 window left, count restarted", 5'b00110);
        tick(1);
        chk("R3 released after full window", 5'b00111);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule